// File: doc/BRIEF.md
# Two-Wire Memory Slave with Write-Enable Latch

This block is a slave on a two-wire serial bus (SCL clock, open-drain SDA data) that gives access to a 272-byte array. The array holds four regions: a 128-byte general-purpose area at 000h–07Fh, a 16-byte block of control and status registers at 080h–08Fh, a first lookup table at 090h–0CFh and a second lookup table at 0D0h–10Fh. Both bus lines are sampled by the system clock through synchronizers. START and STOP conditions are found by edge detection.

Each transaction opens with a START and a slave address byte. A write transaction then carries one word-address byte and zero or more data bytes. A read is made as a write of the word address, a repeated START, and a read-addressed slave byte, after which bytes stream out for as long as the master acknowledges. The bus carries only 8 address bits. A page-select control bit folds the top 16 bytes of the array onto word addresses 00h–0Fh. Every write is gated by a volatile write-enable latch held in the control register, and by rules that protect reserved bits and reserved registers. The pad is modelled as a data-in line, a constant-low data-out and an output enable.

Top module: `tws_slave`

## Requirements
- R1: The slave acknowledges an address byte only when bits 7:4 equal 1010b and bits 3:1 equal `dev_sel_i`. Bit 0 selects read (1) or write (0). Any other address gets no acknowledge, and all bus traffic is ignored until the next START.
- R2: A START anywhere restarts address reception. A STOP returns the slave to idle. SDA is never pulled low while the slave is idle.
- R3: Bytes are shifted most-significant bit first. The slave pulls SDA low in the ninth clock for a matched address, for the word-address byte and for every data byte written.
- R4: The control register at 080h bit 0 is the write-enable latch, and reset clears it. While it is 0, data bytes are acknowledged, but only bit 0 of 080h can change. Every other location and bit keeps its value.
- R5: In 080h only bits 1:0 hold data. In 081h–086h bit 7 is reserved. Reserved bits are stored as 0 and read as 0. Register 087h holds all 8 bits.
- R6: Control bit 080h bit 1 is page select. While it is set, word addresses 00h–0Fh reach array locations 100h–10Fh. All other word addresses reach the array directly.
- R7: A write to 088h–08Fh changes nothing. A read there returns 00h.
- R8: After each written byte the word address increments inside its 16-byte page, so 0Fh is followed by 00h.
- R9: On reads, each master acknowledge advances the word address over the full 8-bit range (0Fh is followed by 10h, FFh by 00h) and starts the next byte. A master no-acknowledge ends the transfer.
- R10: After reset every array location, including both lookup tables, reads 00h.
- R11: When the latch is set, both lookup-table areas and the general-purpose area store a full byte each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_o | output | 1 | Data driven to the pad when enabled, always 0 |
| sda_oe_o | output | 1 | Pad enable. When 1, SDA is pulled low |
| dev_sel_i | input | 3 | Strapped low address bits of the slave |

## Verification
The bench builds the slave with two synchronizer stages and a 16-byte write page, and straps the device-select pins to 101b. A bus bit lasts 32 system clocks, which leaves room for the synchronizer and detector delay before each acknowledge. Page wrap on writes and the full-range read increment are therefore reached at 0Eh–10h and FFh. With the page bit set, the folded 100h–10Fh window sits at low addresses. It can be checked against the untouched general-purpose bytes beneath it.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int          ARRAY_BYTES = 272;
    localparam int          AW          = $clog2(ARRAY_BYTES);
    localparam int          HIGH_BYTES  = ARRAY_BYTES - 256;
    localparam logic [3:0]  DEV_TYPE    = 4'b1010;
    localparam logic [8:0]  CTRL_ADDR   = 9'h080;
    localparam logic [8:0]  PART_LO     = 9'h081;
    localparam logic [8:0]  PART_HI     = 9'h086;
    localparam logic [8:0]  RSV_LO      = 9'h088;
    localparam logic [8:0]  RSV_HI      = 9'h08F;
    localparam int          WEL_BIT     = 0;
    localparam int          PAGE_BIT    = 1;
    localparam logic [7:0]  CTRL_MASK   = 8'h03;
    localparam logic [7:0]  PART_MASK   = 8'h7F;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADR, ST_WADR_ACK,
        ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK
    } link_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic [AW-1:0] map_addr(input logic [7:0] ptr, input logic page);
        if (page && (ptr < 8'(HIGH_BYTES)))
            return AW'(256 + int'(ptr));
        return AW'(ptr);
    endfunction

    function automatic logic [7:0] write_mask(input logic [AW-1:0] a, input logic wel);
        if (a == CTRL_ADDR)                  return wel ? CTRL_MASK : (8'h01 << WEL_BIT);
        if (!wel)                            return 8'h00;
        if ((a >= PART_LO) && (a <= PART_HI)) return PART_MASK;
        if ((a >= RSV_LO) && (a <= RSV_HI))  return 8'h00;
        return 8'hFF;
    endfunction

    function automatic logic read_blocked(input logic [AW-1:0] a);
        return (a >= RSV_LO) && (a <= RSV_HI);
    endfunction

endpackage

// File: rtl/tws_bus_sampler.sv
module tws_bus_sampler
    import tws_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d, scl_s, sda_s;

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_d;
        evt.scl_fall = ~scl_s & scl_d;
        evt.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop     = scl_s & scl_d & ~sda_d & sda_s;
        evt.sda      = sda_s;
    end
endmodule

// File: rtl/tws_link.sv
module tws_link
    import tws_pkg::*;
#(
    parameter int PAGE_BYTES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_evt_t    evt,
    input  logic [2:0]  dev_sel,
    input  logic [7:0]  rd_data,
    output logic        sda_oe,
    output logic [7:0]  ptr,
    output logic        wr_en,
    output logic [7:0]  wr_ptr,
    output logic [7:0]  wr_data,
    output link_state_e state
);
    localparam logic [7:0] PMASK = 8'(PAGE_BYTES - 1);

    logic [3:0] cnt;
    logic [7:0] shreg, tx;
    logic       rw, rack_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            tx      <= '0;
            ptr     <= '0;
            rw      <= 1'b0;
            rack_ok <= 1'b0;
            wr_en   <= 1'b0;
            wr_ptr  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (evt.stop) begin
                state <= ST_IDLE;
            end else if (evt.start) begin
                state <= ST_DEV;
                cnt   <= '0;
            end else begin
                case (state)
                    ST_DEV, ST_WADR, ST_WDAT: begin
                        if (evt.scl_rise) begin
                            shreg <= {shreg[6:0], evt.sda};
                            cnt   <= cnt + 4'd1;
                        end else if (evt.scl_fall && (cnt == 4'd8)) begin
                            cnt <= '0;
                            if (state == ST_DEV) begin
                                if (shreg[7:1] == {DEV_TYPE, dev_sel}) begin
                                    rw    <= shreg[0];
                                    state <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_WADR) begin
                                ptr   <= shreg;
                                state <= ST_WADR_ACK;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_ptr  <= ptr;
                                wr_data <= shreg;
                                ptr     <= (ptr & ~PMASK) | ((ptr + 8'd1) & PMASK);
                                state   <= ST_WDAT_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (evt.scl_fall) begin
                            if (rw) begin
                                tx    <= rd_data;
                                state <= ST_RDAT;
                            end else begin
                                state <= ST_WADR;
                            end
                        end
                    end
                    ST_WADR_ACK, ST_WDAT_ACK: begin
                        if (evt.scl_fall) state <= ST_WDAT;
                    end
                    ST_RDAT: begin
                        if (evt.scl_fall) begin
                            if (cnt == 4'd7) begin
                                cnt     <= '0;
                                rack_ok <= 1'b0;
                                state   <= ST_RACK;
                            end else begin
                                tx  <= {tx[6:0], 1'b0};
                                cnt <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.scl_rise) begin
                            if (evt.sda) begin
                                state <= ST_IDLE;
                            end else begin
                                rack_ok <= 1'b1;
                                ptr     <= ptr + 8'd1;
                            end
                        end else if (evt.scl_fall && rack_ok) begin
                            tx    <= rd_data;
                            state <= ST_RDAT;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_oe = (state == ST_DEV_ACK) || (state == ST_WADR_ACK) ||
                    (state == ST_WDAT_ACK) || ((state == ST_RDAT) && !tx[7]);
endmodule

// File: rtl/tws_array.sv
module tws_array
    import tws_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_ptr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_ptr,
    output logic [7:0] rd_data,
    output logic [7:0] ctrl
);
    logic [7:0]    mem [ARRAY_BYTES];
    logic [AW-1:0] wa, ra;
    logic [7:0]    wm;

    assign ctrl = mem[CTRL_ADDR];
    assign wa   = map_addr(wr_ptr, ctrl[PAGE_BIT]);
    assign ra   = map_addr(rd_ptr, ctrl[PAGE_BIT]);
    assign wm   = write_mask(wa, ctrl[WEL_BIT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wa] <= (mem[wa] & ~wm) | (wr_data & wm);
        end
    end

    assign rd_data = read_blocked(ra) ? 8'h00 : mem[ra];
endmodule

// File: rtl/tws_slave.sv
module tws_slave
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PAGE_BYTES  = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_o,
    output logic       sda_oe_o,
    input  logic [2:0] dev_sel_i
);
    bus_evt_t    evt;
    link_state_e link_state;
    logic [7:0]  ptr, wr_ptr, wr_data, rd_data, ctrl;
    logic        wr_en;

    tws_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .evt(evt)
    );

    tws_link #(.PAGE_BYTES(PAGE_BYTES)) u_link (
        .clk(clk), .rst(rst), .evt(evt), .dev_sel(dev_sel_i),
        .rd_data(rd_data), .sda_oe(sda_oe_o), .ptr(ptr), .wr_en(wr_en),
        .wr_ptr(wr_ptr), .wr_data(wr_data), .state(link_state)
    );

    tws_array u_array (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .wr_data(wr_data), .rd_ptr(ptr), .rd_data(rd_data), .ctrl(ctrl)
    );

    assign sda_o = 1'b0;
endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk
    import tws_pkg::*;
#(
    parameter int PAGE_BYTES = 16
) (
    input logic        clk,
    input logic        rst,
    input bus_evt_t    evt,
    input link_state_e state,
    input logic        sda_oe,
    input logic        wr_en,
    input logic [7:0]  wr_ptr,
    input logic [7:0]  ptr,
    input logic [7:0]  ctrl
);
    localparam int PW = $clog2(PAGE_BYTES);

    // R2
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE));

    // R2
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> !sda_oe);

    // R4
    wel_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ctrl[WEL_BIT]) |=> (ctrl[7:1] == $past(ctrl[7:1])));

    // R5
    ctrl_rsv_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl[7:2] == 6'd0);

    // R8
    page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((ptr[7:PW] == wr_ptr[7:PW]) && (ptr != wr_ptr)));
endmodule

bind tws_slave tws_slave_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk(clk), .rst(rst), .evt(evt), .state(link_state), .sda_oe(sda_oe_o),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .ptr(ptr), .ctrl(ctrl)
);

// File: tb/tws_slave_tb.sv
module tws_slave_tb;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};
    localparam int         Q     = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, m_scl, m_low, sda_o, sda_oe, sda_line;
    int   errors = 0, checks = 0, idle_viol = 0;
    bit   bus_free = 1'b1;
    logic [7:0] ref_mem [272];
    logic [7:0] wq [$];

    assign sda_line = ~(m_low | sda_oe);

    tws_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
        .sda_o(sda_o), .sda_oe_o(sda_oe), .dev_sel_i(STRAP)
    );

    always @(negedge clk) if (!rst && bus_free && sda_oe) idle_viol++;

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic qtr(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    function automatic int mdl_ea(input logic [7:0] p);
        if (ref_mem[128][1] && p < 8'd16) return 256 + int'(p);
        return int'(p);
    endfunction

    task automatic mdl_write(input logic [7:0] p, input logic [7:0] d);
        int         ea;
        logic [7:0] c;
        ea = mdl_ea(p);
        c  = ref_mem[128];
        if (ea == 128)                  ref_mem[128] = c[0] ? (d & 8'h03) : {c[7:1], d[0]};
        else if (!c[0])                 ;
        else if (ea >= 129 && ea <= 134) ref_mem[ea] = d & 8'h7F;
        else if (ea >= 136 && ea <= 143) ;
        else                            ref_mem[ea] = d;
    endtask

    function automatic logic [7:0] mdl_read(input logic [7:0] p);
        int ea;
        ea = mdl_ea(p);
        if (ea >= 136 && ea <= 143) return 8'h00;
        return ref_mem[ea];
    endfunction

    task automatic bus_start();
        bus_free = 1'b0;
        m_low = 1'b0; qtr();
        m_scl = 1'b1; qtr();
        m_low = 1'b1; qtr();
        m_scl = 1'b0; qtr();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; qtr();
        m_scl = 1'b1; qtr();
        m_low = 1'b0; qtr();
        bus_free = 1'b1;
        qtr();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; qtr();
            m_scl = 1'b1;  qtr(2);
            m_scl = 1'b0;  qtr();
        end
        m_low = 1'b0; qtr();
        m_scl = 1'b1; qtr();
        ack = ~sda_line;
        qtr();
        m_scl = 1'b0; qtr();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        m_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            qtr();
            m_scl = 1'b1; qtr();
            b = {b[6:0], sda_line};
            qtr();
            m_scl = 1'b0; qtr();
        end
        m_low = give_ack; qtr();
        m_scl = 1'b1; qtr(2);
        m_scl = 1'b0; qtr();
        m_low = 1'b0;
    endtask

    task automatic wr_txn(input logic [7:0] a, input string req);
        logic       ack;
        logic [7:0] p;
        bus_start();
        send_byte(DEV_W, ack); chk({7'd0, ack}, 8'h01, "R3 address ack");
        send_byte(a, ack);     chk({7'd0, ack}, 8'h01, "R3 word-address ack");
        p = a;
        foreach (wq[i]) begin
            send_byte(wq[i], ack);
            chk({7'd0, ack}, 8'h01, {req, " data ack (R3)"});
            mdl_write(p, wq[i]);
            p = {p[7:4], p[3:0] + 4'd1};
        end
        bus_stop();
        wq.delete();
    endtask

    task automatic rd_txn(input logic [7:0] a, input int n, input string req);
        logic       ack;
        logic [7:0] p, b;
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(a, ack);
        bus_start();
        send_byte(DEV_R, ack); chk({7'd0, ack}, 8'h01, "R1 read address ack");
        p = a;
        for (int i = 0; i < n; i++) begin
            recv_byte(b, (i != n - 1));
            chk(b, mdl_read(p), req);
            p = p + 8'd1;
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic ack;
        for (int i = 0; i < 272; i++) ref_mem[i] = 8'h00;
        rst = 1'b1; m_scl = 1'b1; m_low = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk({7'd0, sda_line}, 8'h01, "R2 line released after reset");

        // R1: wrong type nibble and wrong strap, then ignored traffic
        bus_start();
        send_byte(8'hA2, ack); chk({7'd0, ack}, 8'h00, "R1 strap mismatch nack");
        send_byte(8'h00, ack); chk({7'd0, ack}, 8'h00, "R1 ignored until START");
        bus_stop();
        bus_start();
        send_byte(8'hBA, ack); chk({7'd0, ack}, 8'h00, "R1 type mismatch nack");
        bus_stop();

        // R10: reset contents
        rd_txn(8'h90, 2, "R10 first table zero");
        rd_txn(8'hD0, 2, "R10 second table zero");
        rd_txn(8'h00, 1, "R10 general area zero");

        // R4: latch clear, write discarded
        wq.push_back(8'h11);
        wr_txn(8'h10, "R4 locked");
        rd_txn(8'h10, 1, "R4 locked write discarded");
        wq.push_back(8'hFF);
        wr_txn(8'h80, "R4 set latch while locked");
        rd_txn(8'h80, 1, "R4 only latch bit set");
        wq.push_back(8'h01);
        wr_txn(8'h80, "R4 latch");

        // R5: reserved bits
        wq.push_back(8'hFF); wq.push_back(8'hFF);
        wr_txn(8'h86, "R5 partial regs");
        rd_txn(8'h86, 2, "R5 bit7 reserved / full 087h");

        // R7: reserved registers
        wq.push_back(8'h55); wq.push_back(8'h66);
        wr_txn(8'h88, "R7 reserved");
        rd_txn(8'h88, 2, "R7 reserved reads zero");

        // R8: write page wrap
        wq.push_back(8'hA1); wq.push_back(8'hA2); wq.push_back(8'hA3);
        wr_txn(8'h0E, "R8 wrap");
        rd_txn(8'h0E, 2, "R8 bytes before wrap");
        rd_txn(8'h00, 1, "R8 byte wrapped to page start");

        // R9: read crosses page and 8-bit wrap
        rd_txn(8'h0F, 2, "R9 read crosses page");
        wq.push_back(8'h9C);
        wr_txn(8'hFF, "R9 top byte");
        rd_txn(8'hFF, 2, "R9 read wraps FFh to 00h");

        // R11: lookup tables
        wq.push_back(8'h3C); wr_txn(8'h95, "R11 table one");
        wq.push_back(8'hC3); wr_txn(8'hE0, "R11 table two");
        rd_txn(8'h95, 1, "R11 table one byte");
        rd_txn(8'hE0, 1, "R11 table two byte");

        // R6: page select
        wq.push_back(8'hFF); wr_txn(8'h80, "R5 control write");
        rd_txn(8'h80, 1, "R5 control holds two bits");
        wq.push_back(8'h5A); wr_txn(8'h05, "R6 high page");
        rd_txn(8'h05, 1, "R6 high page byte");
        rd_txn(8'h00, 1, "R6 folded 100h");
        wq.push_back(8'h01); wr_txn(8'h80, "R6 page off");
        rd_txn(8'h05, 1, "R6 low byte untouched");

        // R4: clearing the latch locks again
        wq.push_back(8'h00); wr_txn(8'h80, "R4 clear latch");
        wq.push_back(8'h77); wr_txn(8'h20, "R4 relocked");
        rd_txn(8'h20, 1, "R4 relocked write discarded");

        // R2: STOP mid-transaction, then normal use
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h30, ack);
        bus_stop();
        chk({7'd0, sda_line}, 8'h01, "R2 released after STOP");
        rd_txn(8'h0E, 1, "R2 transfer after STOP");

        checks++;
        if (idle_viol != 0) begin
            errors++;
            $display("FAIL R2 idle drive: actual %0d expected 0", idle_viol);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule